// File: doc/BRIEF.md
# Flash Controller Command, Status and Interrupt Register Core

This block is the register core at the host side of a NAND-style flash controller. It holds a command register, two configuration registers, a controller status register with error flags and an interrupt register with one flag per operation class. The host reaches these registers through a synchronous 16-bit port with a register index. Reads return data one cycle after the read enable.

An accepted command is decoded into a class. Load, program and erase operations go to an array engine as a one-cycle request. When the engine signals done, the block sets the completion flags and, if the engine reports failure, the error flags. Lock, one-time-area and verify commands complete at once. Unknown codes are flagged as command errors. The reset commands perform a warm reset.

The host clears flags by writing an AND mask to the interrupt register. The interrupt pin level follows the master flag, with a polarity set by configuration-1. The ready pin follows a configuration-1 bit.

Top module: `fcsr_core`

## Requirements
- R1: Cold reset (rst_n low) sets interrupt register 0x8080, configuration-1 0x40C0, and configuration-2, status and command 0. A warm reset gives the same values except interrupt 0x8010. A warm reset is triggered by a one-cycle warm_rst pulse or by an accepted command 0x00F0 or 0x00F3.
- R2: Register index 0 is the command register (writes and reads back the code), 1 is configuration-1, 2 is configuration-2, 3 is status (read only) and 4 is the interrupt register. Configuration-1 reads back with bits 4:0 forced to zero. Other indices read 0. Read data appears on rdata in the cycle after rd_en.
- R3: A write to index 4 ANDs wdata into the interrupt register. If bit 15 is zero after the AND, status bits 13:10 are cleared. Otherwise they are kept.
- R4: A command write is discarded, leaving the command register unchanged, while interrupt bit 15 is set or while an engine operation is outstanding.
- R5: An accepted load (0x0000, 0x0013), program (0x0080, 0x001A, 0x001B) or erase (0x0094, 0x0095, 0x0030) command raises eng_req for exactly the next cycle. At the same time eng_kind is 0 for load, 1 for program and 2 for erase, and the operation becomes outstanding.
- R6: eng_done while an operation is outstanding ends it and sets interrupt bit 15 plus bit 7 (load), bit 6 (program) or bit 5 (erase). If eng_fail is also high, status bit 10 is set plus bit 13 (load), bit 12 (program) or bit 11 (erase). eng_done with nothing outstanding has no effect.
- R7: An accepted unknown command code sets status bit 10 and interrupt bit 15 in the same update.
- R8: Commands 0x0023, 0x0027, 0x002A, 0x002C, 0x0065 and 0x0071 set only interrupt bit 15 at once. Command 0x00B0 changes no flag.
- R9: irq_o equals interrupt bit 15 XOR NOT configuration-1 bit 6. rdy_o equals configuration-1 bit 7. Both follow the registers with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_rst | input | 1 | Synchronous warm reset pulse |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| reg_idx | input | 3 | Register index |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, one cycle after rd_en |
| eng_req | output | 1 | One-cycle request to the array engine |
| eng_kind | output | 2 | Operation class of the request: 0 load, 1 program, 2 erase |
| eng_done | input | 1 | Engine completion strobe |
| eng_fail | input | 1 | Engine failure flag, sampled with eng_done |
| irq_o | output | 1 | Interrupt level, polarity from configuration-1 bit 6 |
| rdy_o | output | 1 | Ready level from configuration-1 bit 7 |

## Verification
The main stimulus is a vector walk through every command class. Each command is run with the engine reporting success and then failure, so the program, erase and load flag bits can be told apart, and the matching error bit is checked alongside the shared command-error bit.

The masking writes are tried in two forms. A mask that keeps bit 15 shows that errors survive. A mask that clears bit 15 shows that errors are wiped. Command writes are tried while the master flag is set and while an operation is outstanding, and the command register is read back to show they were dropped. The pin checks flip the configuration bits to separate the polarity select from the master flag itself.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

    localparam int DW    = 16;
    localparam int IDX_W = 3;
    localparam int KW    = 2;

    // register indices
    localparam logic [IDX_W-1:0] RI_CMD  = 3'd0;
    localparam logic [IDX_W-1:0] RI_CFG1 = 3'd1;
    localparam logic [IDX_W-1:0] RI_CFG2 = 3'd2;
    localparam logic [IDX_W-1:0] RI_STAT = 3'd3;
    localparam logic [IDX_W-1:0] RI_INT  = 3'd4;

    // interrupt register bit positions
    localparam int IB_MASTER = 15;
    localparam int IB_WARM   = 4;
    localparam int IB_ERASE  = 5;
    localparam int IB_PROG   = 6;
    localparam int IB_LOAD   = 7;

    // status register bit positions
    localparam int SB_CMD   = 10;
    localparam int SB_ERASE = 11;
    localparam int SB_PROG  = 12;
    localparam int SB_LOAD  = 13;

    // configuration-1 bit positions
    localparam int CB_POL = 6;
    localparam int CB_RDY = 7;
    localparam int CFG1_RD_ZERO = 5;

    localparam logic [DW-1:0] CFG1_RST     = 16'h40C0;
    localparam logic [DW-1:0] INT_COLD_RST = 16'h8080;
    localparam logic [DW-1:0] INT_WARM_RST = 16'h8010;

    typedef enum logic [2:0] {
        CL_LOAD,
        CL_PROG,
        CL_ERASE,
        CL_IMM,
        CL_NOP,
        CL_RESET,
        CL_BAD
    } cmd_class_e;

    typedef enum logic [KW-1:0] {
        K_LOAD  = 2'd0,
        K_PROG  = 2'd1,
        K_ERASE = 2'd2
    } eng_kind_e;

    typedef struct packed {
        logic [DW-1:0] cmd;
        logic [DW-1:0] cfg1;
        logic [DW-1:0] cfg2;
        logic [DW-1:0] stat;
        logic [DW-1:0] intr;
        logic [DW-1:0] rdata;
        logic          busy;
        eng_kind_e     kind;
        logic          req;
    } core_st_t;

endpackage

// File: rtl/fcsr_cmd_decode.sv
module fcsr_cmd_decode
    import fcsr_pkg::*;
(
    input  logic [DW-1:0] code,
    output cmd_class_e    cls
);
    always_comb begin
        unique case (code)
            16'h0000, 16'h0013:                     cls = CL_LOAD;
            16'h0080, 16'h001A, 16'h001B:           cls = CL_PROG;
            16'h0094, 16'h0095, 16'h0030:           cls = CL_ERASE;
            16'h0023, 16'h0027, 16'h002A,
            16'h002C, 16'h0065, 16'h0071:           cls = CL_IMM;
            16'h00B0:                               cls = CL_NOP;
            16'h00F0, 16'h00F3:                     cls = CL_RESET;
            default:                                cls = CL_BAD;
        endcase
    end
endmodule

// File: rtl/fcsr_rd_mux.sv
module fcsr_rd_mux
    import fcsr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    cmd_q,
    input  logic [DW-1:0]    cfg1_q,
    input  logic [DW-1:0]    cfg2_q,
    input  logic [DW-1:0]    stat_q,
    input  logic [DW-1:0]    int_q,
    output logic [DW-1:0]    rd_val
);
    always_comb begin
        unique case (idx)
            RI_CMD:  rd_val = cmd_q;
            RI_CFG1: rd_val = {cfg1_q[DW-1:CFG1_RD_ZERO], {CFG1_RD_ZERO{1'b0}}};
            RI_CFG2: rd_val = cfg2_q;
            RI_STAT: rd_val = stat_q;
            RI_INT:  rd_val = int_q;
            default: rd_val = '0;
        endcase
    end
endmodule

// File: rtl/fcsr_pin_drive.sv
module fcsr_pin_drive
    import fcsr_pkg::*;
(
    input  logic master,
    input  logic cfg_pol,
    input  logic cfg_rdy,
    output logic irq,
    output logic rdy
);
    // polarity bit set: active high; clear: active low
    assign irq = master ^ ~cfg_pol;
    assign rdy = cfg_rdy;
endmodule

// File: rtl/fcsr_core.sv
module fcsr_core
    import fcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             eng_req,
    output logic [KW-1:0]    eng_kind,
    input  logic             eng_done,
    input  logic             eng_fail,
    output logic             irq_o,
    output logic             rdy_o
);
    core_st_t   st_d, st_q;
    cmd_class_e cls;
    logic [DW-1:0] rd_val;
    logic [DW-1:0] cmd_q, cfg1_q, cfg2_q, stat_q, int_q;
    logic          busy_q;
    logic          cmd_ok;
    logic          warm_go;

    assign cmd_q  = st_q.cmd;
    assign cfg1_q = st_q.cfg1;
    assign cfg2_q = st_q.cfg2;
    assign stat_q = st_q.stat;
    assign int_q  = st_q.intr;
    assign busy_q = st_q.busy;

    fcsr_cmd_decode i_dec (
        .code (wdata),
        .cls  (cls)
    );

    fcsr_rd_mux i_rd (
        .idx    (reg_idx),
        .cmd_q  (cmd_q),
        .cfg1_q (cfg1_q),
        .cfg2_q (cfg2_q),
        .stat_q (stat_q),
        .int_q  (int_q),
        .rd_val (rd_val)
    );

    fcsr_pin_drive i_pin (
        .master  (int_q[IB_MASTER]),
        .cfg_pol (cfg1_q[CB_POL]),
        .cfg_rdy (cfg1_q[CB_RDY]),
        .irq     (irq_o),
        .rdy     (rdy_o)
    );

    assign cmd_ok = wr_en && (reg_idx == RI_CMD) && !int_q[IB_MASTER] && !busy_q;

    always_comb begin
        st_d    = st_q;
        st_d.req = 1'b0;
        warm_go = 1'b0;

        if (rd_en) begin
            st_d.rdata = rd_val;
        end

        // plain register writes
        if (wr_en) begin
            unique case (reg_idx)
                RI_CFG1: st_d.cfg1 = wdata;
                RI_CFG2: st_d.cfg2 = wdata;
                RI_INT: begin
                    st_d.intr = st_q.intr & wdata;
                    if (!st_d.intr[IB_MASTER]) begin
                        st_d.stat[SB_LOAD:SB_CMD] = '0;
                    end
                end
                default: ;
            endcase
        end

        // command acceptance
        if (cmd_ok) begin
            st_d.cmd = wdata;
            unique case (cls)
                CL_LOAD: begin
                    st_d.busy = 1'b1;
                    st_d.kind = K_LOAD;
                    st_d.req  = 1'b1;
                end
                CL_PROG: begin
                    st_d.busy = 1'b1;
                    st_d.kind = K_PROG;
                    st_d.req  = 1'b1;
                end
                CL_ERASE: begin
                    st_d.busy = 1'b1;
                    st_d.kind = K_ERASE;
                    st_d.req  = 1'b1;
                end
                CL_IMM: st_d.intr[IB_MASTER] = 1'b1;
                CL_NOP: ;
                CL_RESET: warm_go = 1'b1;
                default: begin
                    st_d.stat[SB_CMD]    = 1'b1;
                    st_d.intr[IB_MASTER] = 1'b1;
                end
            endcase
        end

        // engine completion, merged after any host mask
        if (eng_done && busy_q) begin
            st_d.busy            = 1'b0;
            st_d.intr[IB_MASTER] = 1'b1;
            unique case (st_q.kind)
                K_LOAD:  st_d.intr[IB_LOAD]  = 1'b1;
                K_PROG:  st_d.intr[IB_PROG]  = 1'b1;
                default: st_d.intr[IB_ERASE] = 1'b1;
            endcase
            if (eng_fail) begin
                st_d.stat[SB_CMD] = 1'b1;
                unique case (st_q.kind)
                    K_LOAD:  st_d.stat[SB_LOAD]  = 1'b1;
                    K_PROG:  st_d.stat[SB_PROG]  = 1'b1;
                    default: st_d.stat[SB_ERASE] = 1'b1;
                endcase
            end
        end

        if (warm_go || warm_rst) begin
            st_d.cmd  = '0;
            st_d.cfg1 = CFG1_RST;
            st_d.cfg2 = '0;
            st_d.stat = '0;
            st_d.intr = INT_WARM_RST;
            st_d.busy = 1'b0;
            st_d.kind = K_LOAD;
            st_d.req  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmd   <= '0;
            st_q.cfg1  <= CFG1_RST;
            st_q.cfg2  <= '0;
            st_q.stat  <= '0;
            st_q.intr  <= INT_COLD_RST;
            st_q.rdata <= '0;
            st_q.busy  <= 1'b0;
            st_q.kind  <= K_LOAD;
            st_q.req   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign eng_req  = st_q.req;
    assign eng_kind = st_q.kind;

endmodule

// File: rtl/fcsr_core_chk.sv
module fcsr_core_chk
    import fcsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             warm_rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] reg_idx,
    input logic             eng_req,
    input logic             eng_done,
    input logic             irq_o,
    input logic [DW-1:0]    cmd_q,
    input logic [DW-1:0]    cfg1_q,
    input logic [DW-1:0]    stat_q,
    input logic [DW-1:0]    int_q,
    input logic             busy_q
);
    p_cmd_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == RI_CMD && int_q[IB_MASTER] && !warm_rst) |=> $stable(cmd_q));

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && busy_q) |=> int_q[IB_MASTER]);

    p_err_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_q[IB_MASTER]) |-> (stat_q[SB_LOAD:SB_CMD] == '0));

    p_err_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[SB_CMD] |-> int_q[IB_MASTER]);

    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (int_q[IB_MASTER] == cfg1_q[CB_POL]));
endmodule

bind fcsr_core fcsr_core_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_rst (warm_rst),
    .wr_en    (wr_en),
    .reg_idx  (reg_idx),
    .eng_req  (eng_req),
    .eng_done (eng_done),
    .irq_o    (irq_o),
    .cmd_q    (cmd_q),
    .cfg1_q   (cfg1_q),
    .stat_q   (stat_q),
    .int_q    (int_q),
    .busy_q   (busy_q)
);

// File: tb/test_fcsr_core.sv
`timescale 1ns/1ps
module test_fcsr_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        eng_req;
    logic [1:0]  eng_kind;
    logic        eng_done = 1'b0;
    logic        eng_fail = 1'b0;
    logic        irq_o;
    logic        rdy_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fcsr_core i_fcsr_core (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx), .wdata(wdata),
        .rdata(rdata), .eng_req(eng_req), .eng_kind(eng_kind),
        .eng_done(eng_done), .eng_fail(eng_fail), .irq_o(irq_o), .rdy_o(rdy_o)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DN = 2'd2;
    localparam logic [2:0] XC = 3'd0, X1 = 3'd1, X2 = 3'd2, XS = 3'd3, XI = 3'd4;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  idx;
        logic [15:0] val;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, XI, 16'h8080, 4'd1},   // R1 cold interrupt value
        '{OP_RD, X1, 16'h40C0, 4'd1},   // R1
        '{OP_RD, XS, 16'h0000, 4'd1},   // R1
        '{OP_WR, XC, 16'h0080, 4'd4},
        '{OP_RD, XC, 16'h0000, 4'd4},   // R4 dropped while master set
        '{OP_WR, XI, 16'h0000, 4'd3},
        '{OP_RD, XI, 16'h0000, 4'd3},   // R3
        '{OP_WR, XC, 16'h0000, 4'd5},
        '{OP_DN, 3'd0, 16'h0000, 4'd6},
        '{OP_RD, XI, 16'h8080, 4'd6},   // R6 load done
        '{OP_RD, XS, 16'h0000, 4'd6},   // R6
        '{OP_WR, XI, 16'h0000, 4'd3},
        '{OP_WR, XC, 16'h0080, 4'd5},
        '{OP_DN, 3'd0, 16'h0001, 4'd6},
        '{OP_RD, XI, 16'h8040, 4'd6},   // R6 program flag
        '{OP_RD, XS, 16'h1400, 4'd6},   // R6 program error
        '{OP_WR, XI, 16'h8000, 4'd3},
        '{OP_RD, XS, 16'h1400, 4'd3},   // R3 errors kept
        '{OP_RD, XI, 16'h8000, 4'd3},   // R3
        '{OP_WR, XI, 16'h0000, 4'd3},
        '{OP_RD, XS, 16'h0000, 4'd3},   // R3 errors cleared
        '{OP_WR, XC, 16'h0094, 4'd5},
        '{OP_RD, XC, 16'h0094, 4'd2},   // R2 command readback
        '{OP_DN, 3'd0, 16'h0001, 4'd6},
        '{OP_RD, XI, 16'h8020, 4'd6},   // R6 erase flag
        '{OP_RD, XS, 16'h0C00, 4'd6},   // R6 erase error
        '{OP_WR, XI, 16'h0000, 4'd3},
        '{OP_WR, XC, 16'h0055, 4'd7},
        '{OP_RD, XI, 16'h8000, 4'd7},   // R7
        '{OP_RD, XS, 16'h0400, 4'd7},   // R7
        '{OP_WR, XI, 16'h0000, 4'd3},
        '{OP_WR, XC, 16'h001B, 4'd5},
        '{OP_DN, 3'd0, 16'h0000, 4'd6},
        '{OP_RD, XI, 16'h8040, 4'd6},   // R6 copy-back is program class
        '{OP_WR, XI, 16'h0000, 4'd3},
        '{OP_WR, XC, 16'h0013, 4'd5},
        '{OP_DN, 3'd0, 16'h0001, 4'd6},
        '{OP_RD, XS, 16'h2400, 4'd6},   // R6 load error
        '{OP_RD, XI, 16'h8080, 4'd6},   // R6
        '{OP_WR, XI, 16'h0000, 4'd3},
        '{OP_WR, XC, 16'h0030, 4'd5},
        '{OP_DN, 3'd0, 16'h0000, 4'd6},
        '{OP_RD, XI, 16'h8020, 4'd6},   // R6 resume is erase class
        '{OP_WR, XI, 16'h0000, 4'd3},
        '{OP_WR, XC, 16'h002A, 4'd8},
        '{OP_RD, XI, 16'h8000, 4'd8},   // R8 immediate
        '{OP_WR, XI, 16'h0000, 4'd3},
        '{OP_WR, XC, 16'h00B0, 4'd8},
        '{OP_RD, XI, 16'h0000, 4'd8},   // R8 no flag
        '{OP_WR, X1, 16'h40DF, 4'd2},
        '{OP_RD, X1, 16'h40C0, 4'd2},   // R2 low bits masked
        '{OP_WR, X2, 16'h1234, 4'd2},
        '{OP_RD, X2, 16'h1234, 4'd2},   // R2
        '{OP_RD, 3'd7, 16'h0000, 4'd2}, // R2 unmapped index
        '{OP_WR, XC, 16'h00F3, 4'd1},
        '{OP_RD, XI, 16'h8010, 4'd1},   // R1 warm value
        '{OP_RD, X2, 16'h0000, 4'd1},   // R1
        '{OP_RD, XC, 16'h0000, 4'd1}    // R1
    };

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = idx; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic done(input logic fail);
        @(negedge clk);
        eng_done = 1'b1; eng_fail = fail;
        @(negedge clk);
        eng_done = 1'b0; eng_fail = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R5", {15'd0, eng_req}, 16'h0000);
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR: wr(VEC[i].idx, VEC[i].val);
                OP_RD: begin
                    rd(VEC[i].idx, v);
                    chk($sformatf("R%0d", VEC[i].rq), v, VEC[i].val);
                end
                default: done(VEC[i].val[0]);
            endcase
        end

        // R5 request pulse and kind, then R4 drop while outstanding
        wr(XI, 16'h0000);
        wr(XC, 16'h001A);
        chk("R5 req", {15'd0, eng_req}, 16'h0001);
        chk("R5 kind", {14'd0, eng_kind}, 16'h0001);
        @(negedge clk);
        chk("R5 pulse end", {15'd0, eng_req}, 16'h0000);
        wr(XC, 16'h0080);
        rd(XC, v);
        chk("R4 busy drop", v, 16'h001A);
        done(1'b0);
        rd(XI, v);
        chk("R6", v, 16'h8040);
        wr(XI, 16'h0000);
        wr(XC, 16'h0095);
        chk("R5 erase kind", {14'd0, eng_kind}, 16'h0002);
        done(1'b0);

        // R6 stray done ignored
        wr(XI, 16'h0000);
        done(1'b1);
        rd(XI, v);
        chk("R6 stray done", v, 16'h0000);
        rd(XS, v);
        chk("R6 stray done", v, 16'h0000);

        // R9 pin levels
        chk("R9 irq", {15'd0, irq_o}, 16'h0000);
        chk("R9 rdy", {15'd0, rdy_o}, 16'h0001);
        wr(X1, 16'h0000);
        chk("R9 irq inv", {15'd0, irq_o}, 16'h0001);
        chk("R9 rdy low", {15'd0, rdy_o}, 16'h0000);
        wr(XC, 16'h0071);
        chk("R9 irq active low", {15'd0, irq_o}, 16'h0000);

        // R1 warm reset pin
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
        rd(XI, v);
        chk("R1 warm pin", v, 16'h8010);
        rd(X1, v);
        chk("R1 warm cfg1", v, 16'h40C0);

        // R1 cold reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(XI, v);
        chk("R1 cold", v, 16'h8080);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule